// File: doc/BRIEF.md
# Asynchronous Serial Byte Receiver with Error Reporting

This block turns a single asynchronous serial input line into bytes. It watches the line with a 16x oversampling tick that an external baud-rate generator supplies. It finds the falling edge of a start bit and rejects short glitches. It then samples eight data bits, least significant bit first, each in the middle of its bit period. After the data bits it takes an optional parity bit and one stop bit. A finished byte goes into a one-byte holding buffer. The block raises a one-cycle completion pulse when it writes the buffer, and a one-cycle error pulse when the frame had a problem.

Reception needs two controls: a power gate and a receive enable. The receiver arms only after the power gate has been high for at least one full clock cycle and the receive enable is also high. Dropping either control stops an active frame at once and returns the receiver to idle. A parity or framing problem does not cut the frame short; it is reported at the stop-bit sample, together with the buffer write. If the previous byte has not been read when a new frame completes, the new byte is thrown away and an overrun is recorded. All three error flags stay set until a clear strobe arrives.

Top module: `serialRxUnit`

## Requirements
- R1: The receiver is armed only when `powerOn` was high in the previous clock cycle and both `powerOn` and `rxEnable` are high now. While it is not armed, activity on `rxLine` produces no byte, no pulse and no flag.
- R2: A start bit begins when an armed, idle receiver sees a low line on a tick. The line is checked again 8 ticks later. If the line is high at that check, the start is dropped as a glitch, the receiver returns to idle, and nothing is reported.
- R3: Data bits are sampled every 16 ticks after the start-bit check (ticks 24, 40, …, 136 counted from the detection tick). They are taken least significant bit first, and the byte appears on `rxData`.
- R4: On the stop-bit sample, a receiver whose buffer is free writes the byte to `rxData`. On the same clock edge it pulses `rxDone` high for one cycle and sets `bufFull`. A `readStrobe` clears `bufFull`, and a read in the same cycle as a completion frees the buffer for that byte.
- R5: If a frame completes while `bufFull` is set and no `readStrobe` arrives in that cycle, the new byte is discarded and `rxData` keeps the old byte. `overrunFlag` is set, `errPulse` pulses, and `rxDone` stays low.
- R6: `parityMode` selects the parity handling: 2'b00 and 2'b11 mean no parity bit, 2'b01 means even, 2'b10 means odd. The parity bit follows D7 and is sampled 16 ticks after it. A mismatch sets `parityFlag`, and the byte is still written.
- R7: A low line at the stop-bit sample sets `framingFlag`, and the byte is still written.
- R8: Errors are reported only at the stop-bit sample: `errPulse` pulses for one cycle on the same edge as the buffer write or the discard. Without parity, the stop sample falls on tick 152; with parity, on tick 168.
- R9: Only one stop bit is checked. A new start bit may begin right after the stop bit period, and any further high bits are treated as idle line.
- R10: `overrunFlag`, `parityFlag` and `framingFlag` are sticky until `clearStrobe`. If a clear and a new error arrive in the same cycle, the error wins.
- R11: Dropping `rxEnable` (or `powerOn`) during a frame abandons it at once. The partial frame is never reported, and a later frame is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| powerOn | input | 1 | Power gate for the receiver |
| rxEnable | input | 1 | Receive enable, effective once power is on |
| tick16 | input | 1 | One-cycle tick at 16x the bit rate |
| rxLine | input | 1 | Serial input line, idle high |
| parityMode | input | 2 | 00/11 none, 01 even, 10 odd |
| readStrobe | input | 1 | Marks the buffered byte as read |
| clearStrobe | input | 1 | Clears the sticky error flags |
| rxData | output | 8 | Holding buffer contents |
| rxDone | output | 1 | One-cycle pulse when a byte is written |
| errPulse | output | 1 | One-cycle pulse when a frame ends with an error |
| bufFull | output | 1 | Buffer holds an unread byte |
| overrunFlag | output | 1 | Sticky overrun flag |
| parityFlag | output | 1 | Sticky parity error flag |
| framingFlag | output | 1 | Sticky framing error flag |

## Verification
The bench drives bytes with a single bit set in the lowest or highest position, so a reversed bit order or a one-period sampling slip shows up. It also drives alternating patterns (A5, 5A, C3, 96), which show whether each bit is sampled in the middle of its own period. The same bytes are sent with no parity, even parity and odd parity, both with a correct parity bit and with a flipped one; this tells a wrong parity sense apart from a missing parity slot. Further patterns cover a low stop bit, two frames without a read in between, a short low glitch, a frame cut off by dropping the enable, and frames sent while the block is not armed. Each of these is followed by a clean frame, which shows that the receiver has recovered.

// File: rtl/serialRxPkg.sv
package serialRxPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } rxState_t;

  typedef struct packed {
    logic takeData;
    logic takeParity;
    logic finish;
  } rxStrobe_t;

  localparam logic [1:0] PAR_EVEN = 2'b01;
  localparam logic [1:0] PAR_ODD  = 2'b10;

  function automatic logic parityUsed(input logic [1:0] mode);
    return (mode == PAR_EVEN) || (mode == PAR_ODD);
  endfunction

endpackage

// File: rtl/serialRxCtrl.sv
module serialRxCtrl
  import serialRxPkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      armed,
  input  logic      tick,
  input  logic      lineS,
  input  logic      parityOn,
  output rxStrobe_t strobe
);
  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam int IDX_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OVERSAMPLE - 1);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVERSAMPLE / 2 - 1);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(DATA_BITS - 1);

  rxState_t         state;
  logic [CNT_W-1:0] tickCnt;
  logic [IDX_W-1:0] bitIdx;
  logic             midFull;
  logic             midHalf;

  assign midFull = (tickCnt == FULL_LAST);
  assign midHalf = (tickCnt == HALF_LAST);

  always_ff @(posedge clk) begin
    if (!rstN || !armed) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else if (tick) begin
      case (state)
        ST_IDLE: begin
          tickCnt <= '0;
          if (!lineS) state <= ST_START;
        end
        ST_START: begin
          if (midHalf) begin
            tickCnt <= '0;
            bitIdx  <= '0;
            state   <= lineS ? ST_IDLE : ST_DATA;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (midFull) begin
            tickCnt <= '0;
            if (bitIdx == IDX_LAST) state <= parityOn ? ST_PARITY : ST_STOP;
            else bitIdx <= bitIdx + 1'b1;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_PARITY: begin
          if (midFull) begin
            tickCnt <= '0;
            state   <= ST_STOP;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (midFull) begin
            tickCnt <= '0;
            state   <= ST_IDLE;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe = '0;
    if (armed && tick && midFull) begin
      strobe.takeData   = (state == ST_DATA);
      strobe.takeParity = (state == ST_PARITY);
      strobe.finish     = (state == ST_STOP);
    end
  end

endmodule

// File: rtl/serialRxDatapath.sv
module serialRxDatapath
  import serialRxPkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 lineS,
  input  rxStrobe_t            strobe,
  input  logic [1:0]           parityMode,
  input  logic                 readStrobe,
  input  logic                 clearStrobe,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxDone,
  output logic                 errPulse,
  output logic                 bufFull,
  output logic                 overrunFlag,
  output logic                 parityFlag,
  output logic                 framingFlag
);
  logic [DATA_BITS-1:0] shiftReg;
  logic                 parBit;
  logic                 parBad;
  logic                 frameBad;
  logic                 slotFree;

  assign parBad   = parityUsed(parityMode) &&
                    ((^shiftReg) ^ parBit ^ (parityMode == PAR_ODD));
  assign frameBad = !lineS;
  assign slotFree = !bufFull || readStrobe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else begin
      if (strobe.takeData)   shiftReg <= {lineS, shiftReg[DATA_BITS-1:1]};
      if (strobe.takeParity) parBit   <= lineS;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData      <= '0;
      rxDone      <= 1'b0;
      errPulse    <= 1'b0;
      bufFull     <= 1'b0;
      overrunFlag <= 1'b0;
      parityFlag  <= 1'b0;
      framingFlag <= 1'b0;
    end else begin
      rxDone   <= 1'b0;
      errPulse <= 1'b0;
      if (readStrobe) bufFull <= 1'b0;
      if (clearStrobe) begin
        overrunFlag <= 1'b0;
        parityFlag  <= 1'b0;
        framingFlag <= 1'b0;
      end
      if (strobe.finish) begin
        if (slotFree) begin
          rxData  <= shiftReg;
          bufFull <= 1'b1;
          rxDone  <= 1'b1;
        end else begin
          overrunFlag <= 1'b1;
        end
        if (parBad)   parityFlag  <= 1'b1;
        if (frameBad) framingFlag <= 1'b1;
        errPulse <= parBad || frameBad || !slotFree;
      end
    end
  end

endmodule

// File: rtl/serialRxUnit.sv
module serialRxUnit
  import serialRxPkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 powerOn,
  input  logic                 rxEnable,
  input  logic                 tick16,
  input  logic                 rxLine,
  input  logic [1:0]           parityMode,
  input  logic                 readStrobe,
  input  logic                 clearStrobe,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxDone,
  output logic                 errPulse,
  output logic                 bufFull,
  output logic                 overrunFlag,
  output logic                 parityFlag,
  output logic                 framingFlag
);
  logic [SYNC_DEPTH-1:0] syncChain;
  logic                  lineS;
  logic                  powerSeen;
  logic                  armed;
  rxStrobe_t             strobe;

  generate
    if (SYNC_DEPTH == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rstN) syncChain <= '1;
        else       syncChain <= rxLine;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rstN) syncChain <= '1;
        else       syncChain <= {syncChain[SYNC_DEPTH-2:0], rxLine};
      end
    end
  endgenerate

  assign lineS = syncChain[SYNC_DEPTH-1];

  always_ff @(posedge clk) begin
    if (!rstN) powerSeen <= 1'b0;
    else       powerSeen <= powerOn;
  end

  assign armed = powerSeen && powerOn && rxEnable;

  serialRxCtrl #(
    .OVERSAMPLE(OVERSAMPLE),
    .DATA_BITS (DATA_BITS)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .armed   (armed),
    .tick    (tick16),
    .lineS   (lineS),
    .parityOn(parityUsed(parityMode)),
    .strobe  (strobe)
  );

  serialRxDatapath #(
    .DATA_BITS(DATA_BITS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .lineS      (lineS),
    .strobe     (strobe),
    .parityMode (parityMode),
    .readStrobe (readStrobe),
    .clearStrobe(clearStrobe),
    .rxData     (rxData),
    .rxDone     (rxDone),
    .errPulse   (errPulse),
    .bufFull    (bufFull),
    .overrunFlag(overrunFlag),
    .parityFlag (parityFlag),
    .framingFlag(framingFlag)
  );

endmodule

// File: rtl/serialRxUnit_chk.sv
module serialRxUnit_chk #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 rxEnable,
  input logic                 readStrobe,
  input logic                 clearStrobe,
  input logic [DATA_BITS-1:0] rxData,
  input logic                 rxDone,
  input logic                 errPulse,
  input logic                 bufFull,
  input logic                 overrunFlag,
  input logic                 parityFlag,
  input logic                 framingFlag
);

  // R4: a written byte always leaves the buffer marked full
  p_done_fills_buffer_r4: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |-> bufFull);

  // R5: an overrun keeps the old byte and suppresses the completion pulse
  p_overrun_keeps_data_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrunFlag) |-> ($stable(rxData) && !rxDone && errPulse));

  // R8: completion is a single-cycle pulse
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |=> !rxDone);

  // R8: an error pulse is always backed by a sticky flag
  p_err_has_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> (overrunFlag || parityFlag || framingFlag));

  // R10: flags hold until cleared
  p_parity_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (parityFlag && !clearStrobe) |=> parityFlag);

  p_framing_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (framingFlag && !clearStrobe) |=> framingFlag);

  // R11: with reception disabled no frame can complete on the next edge
  p_disabled_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> (!rxDone && !errPulse));

  // R4: the buffer stays full until a read
  p_full_holds_r4: assert property (@(posedge clk) disable iff (!rstN)
    (bufFull && !readStrobe) |=> bufFull);

endmodule

bind serialRxUnit serialRxUnit_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .rxEnable   (rxEnable),
  .readStrobe (readStrobe),
  .clearStrobe(clearStrobe),
  .rxData     (rxData),
  .rxDone     (rxDone),
  .errPulse   (errPulse),
  .bufFull    (bufFull),
  .overrunFlag(overrunFlag),
  .parityFlag (parityFlag),
  .framingFlag(framingFlag)
);

// File: tb/sim_serialRxUnit.sv
`timescale 1ns/1ps
module sim_serialRxUnit;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       powerOn = 1'b0;
  logic       rxEnable = 1'b0;
  logic       tick16 = 1'b0;
  logic       rxLine = 1'b1;
  logic [1:0] parityMode = 2'b00;
  logic       readStrobe = 1'b0;
  logic       clearStrobe = 1'b0;
  logic [7:0] rxData;
  logic       rxDone, errPulse, bufFull, overrunFlag, parityFlag, framingFlag;

  always #4 clk = ~clk;

  serialRxUnit u0 (
    .clk(clk), .rstN(rstN), .powerOn(powerOn), .rxEnable(rxEnable),
    .tick16(tick16), .rxLine(rxLine), .parityMode(parityMode),
    .readStrobe(readStrobe), .clearStrobe(clearStrobe), .rxData(rxData),
    .rxDone(rxDone), .errPulse(errPulse), .bufFull(bufFull),
    .overrunFlag(overrunFlag), .parityFlag(parityFlag), .framingFlag(framingFlag)
  );

  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;
  string curReq = "R4";

  logic       pwrV = 1'b0, enV = 1'b0;
  logic [7:0] expData = 8'h00;
  logic       expDone = 0, expErr = 0, expFull = 0, expOvr = 0, expPar = 0, expFrm = 0;
  logic       parErrNow = 0, frmErrNow = 0;
  logic [7:0] byteNow = 8'h00;

  task automatic compareAll();
    logic [12:0] got, exp;
    got = {rxData, rxDone, errPulse, bufFull, overrunFlag, parityFlag, framingFlag};
    exp = {expData, expDone, expErr, expFull, expOvr, expPar, expFrm};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: {data,done,err,full,ovr,par,frm} got %h/%b expected %h/%b at %0t",
               curReq, got[12:5], got[4:0], exp[12:5], exp[4:0], $time);
    end
  endtask

  // One clock: check outputs, apply inputs, advance the reference model.
  task automatic step(input logic tk, input logic ln, input logic rd,
                      input logic clr, input logic fin);
    @(negedge clk);
    compareAll();
    tick16 = tk; rxLine = ln; readStrobe = rd; clearStrobe = clr;
    powerOn = pwrV; rxEnable = enV;
    expDone = 0;
    expErr  = 0;
    if (rd) expFull = 0;
    if (clr) begin expOvr = 0; expPar = 0; expFrm = 0; end
    if (fin) begin
      if (!expFull) begin
        expData = byteNow; expFull = 1; expDone = 1;
      end else begin
        expOvr = 1;
      end
      if (parErrNow) expPar = 1;
      if (frmErrNow) expFrm = 1;
      expErr = parErrNow || frmErrNow || !expDone;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic doRead();
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    idle(2);
  endtask

  task automatic doClear();
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    idle(2);
  endtask

  // One tick period = four clocks; the line changes three clocks before the tick.
  task automatic tickGroup(input logic ln, input logic fin);
    step(1'b0, ln, 1'b0, 1'b0, 1'b0);
    step(1'b0, ln, 1'b0, 1'b0, 1'b0);
    step(1'b0, ln, 1'b0, 1'b0, 1'b0);
    step(1'b1, ln, 1'b0, 1'b0, fin);
  endtask

  task automatic sendFrame(input logic [7:0] b, input logic flipPar, input logic stopVal,
                           input bit expectRx, input int abortTick, input int idleAfter);
    bit   usePar;
    int   nb, stopTick;
    logic pbit, ln;
    usePar   = (parityMode == 2'b01) || (parityMode == 2'b10);
    nb       = usePar ? 11 : 10;
    stopTick = 8 + 16 * (nb - 1);
    pbit     = (parityMode == 2'b10) ? ~(^b) : (^b);
    if (flipPar) pbit = ~pbit;
    byteNow   = b;
    parErrNow = usePar && flipPar;
    frmErrNow = !stopVal;
    for (int t = 0; t < nb * 16 + idleAfter; t++) begin
      int bi;
      bi = t / 16;
      if (bi == 0) ln = 1'b0;
      else if (bi <= 8) ln = b[bi-1];
      else if (usePar && bi == 9) ln = pbit;
      else if (bi == nb - 1) ln = stopVal;
      else ln = 1'b1;
      if (t == abortTick) enV = 1'b0;
      tickGroup(ln, expectRx && (t == stopTick));
    end
  endtask

  task automatic glitch(input int lowTicks);
    for (int t = 0; t < 24; t++) tickGroup((t < lowTicks) ? 1'b0 : 1'b1, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    curReq = "R4";
    idle(5);                   // reset state is checked on every step
    rstN = 1'b1;
    idle(3);

    // Not armed: power off with enable on, then power on with enable off
    curReq = "R1";
    pwrV = 0; enV = 1;
    idle(2);
    sendFrame(8'hA5, 0, 1, 0, -1, 16);
    pwrV = 1; enV = 0;
    idle(2);
    sendFrame(8'hA5, 0, 1, 0, -1, 16);

    // Armed, no parity: several bit patterns
    enV = 1;
    idle(2);
    curReq = "R3";
    sendFrame(8'h5A, 0, 1, 1, -1, 16);
    doRead();
    sendFrame(8'h01, 0, 1, 1, -1, 16);
    doRead();
    sendFrame(8'h80, 0, 1, 1, -1, 16);
    curReq = "R4";
    doRead();

    // Parity: even and odd, good and bad; the flag stays set across a clean frame
    curReq = "R6";
    parityMode = 2'b01;
    sendFrame(8'h37, 0, 1, 1, -1, 16);
    doRead();
    sendFrame(8'h37, 1, 1, 1, -1, 16);
    doRead();
    parityMode = 2'b10;
    curReq = "R10";
    sendFrame(8'hC3, 0, 1, 1, -1, 16);
    doRead();
    doClear();
    curReq = "R6";
    sendFrame(8'hC3, 1, 1, 1, -1, 16);
    doRead();
    doClear();
    parityMode = 2'b11;
    sendFrame(8'hE7, 0, 1, 1, -1, 16);
    doRead();
    parityMode = 2'b00;

    // Framing: low stop bit, byte still written, reported at the stop sample
    curReq = "R7";
    sendFrame(8'h3C, 0, 0, 1, -1, 24);
    doRead();
    curReq = "R10";
    doClear();

    // Overrun: second byte without a read is discarded
    curReq = "R5";
    sendFrame(8'h11, 0, 1, 1, -1, 16);
    sendFrame(8'h22, 0, 1, 1, -1, 16);
    doRead();
    doClear();

    // Glitch rejection, then a clean frame
    curReq = "R2";
    glitch(4);
    sendFrame(8'h96, 0, 1, 1, -1, 16);
    doRead();

    // Abort mid-frame by dropping the enable, then a fresh frame
    curReq = "R11";
    sendFrame(8'hFF, 0, 1, 0, 60, 0);
    idle(8);
    enV = 1;
    idle(4);
    sendFrame(8'h4B, 0, 1, 1, -1, 16);
    doRead();

    // Back-to-back frames with a single stop bit and no idle gap
    curReq = "R9";
    sendFrame(8'h12, 0, 1, 1, -1, 0);
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    sendFrame(8'h34, 0, 1, 1, -1, 16);
    curReq = "R8";
    doRead();
    idle(4);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule